// File: doc/BRIEF.md
# Dual-Mode Raster Sync Timing Generator

This block produces the raster timing for a display driven from one fixed 50 MHz clock. It outputs horizontal and vertical sync, a flag that is high over the visible area, the column and row of the current pixel, and a strobe that is high for one clock at the start of each line. Downstream colour logic uses the coordinates and the visible flag to decide what to draw.

A mode input picks one of two rasters. Mode 0 is 800x600 at 72 Hz with one clock per pixel. Mode 1 is 640x480 at 60 Hz with two clocks per pixel. Both counters count from the first visible pixel and the first visible line, so coordinate zero is the top-left visible pixel. Every interval length is a parameter. The defaults give the two standard rasters, and a scaled-down set can be used for fast simulation.

Top module: `vga_sync_gen`

## Requirements
- R1: The internal clock count advances by one on every clock and wraps to 0 after the last clock of a line. A line lasts 1040 clocks in mode 0 and 1600 clocks in mode 1. In mode 0 the column output equals the clock count.
- R2: The row advances by one once per line and wraps to 0 after the last line of a frame. A frame lasts 666 lines in mode 0 and 521 lines in mode 1.
- R3: Horizontal sync is low exactly while the clock count lies in the pulse interval and is high otherwise. The interval is 816..935 in mode 0 and 1312..1503 in mode 1.
- R4: Vertical sync is low exactly while the row lies in the pulse interval and is high otherwise. The interval is 637..642 in mode 0 and 490..491 in mode 1.
- R5: The visible flag is 1 only when the clock count and the row both lie in their display ranges. The display ranges are 0..799 and 0..599 in mode 0, and 0..1279 and 0..479 in mode 1.
- R6: The line-start strobe is high exactly in the cycles where the clock count is 0, which is one clock per line. The row output changes only in a cycle where the strobe is high.
- R7: In mode 1 the column output is the clock count shifted right by one, so it ranges from 0 to 639.
- R8: While reset is high, both counters are 0, both syncs are high and the strobe is high.
- R9: The mode input is sampled only while reset is high. A change of the mode input outside reset has no effect on any output. Mode encoding: 0 selects 800x600, 1 selects 640x480.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 50 MHz clock |
| rst_i | input | 1 | Synchronous reset, active high |
| mode_i | input | 1 | Raster select (0: 800x600, 1: 640x480), captured during reset |
| hsync_o | output | 1 | Horizontal sync, low during the pulse |
| vsync_o | output | 1 | Vertical sync, low during the pulse |
| visible_o | output | 1 | High over the visible area |
| pix_col_o | output | 11 | Pixel column of the current clock |
| pix_row_o | output | 10 | Pixel row of the current line |
| line_start_o | output | 1 | One-clock strobe at column count 0 |

## Verification
The bench uses a scaled-down set of interval lengths and follows every cycle of two full frames in each mode. Each output is compared against a count derived arithmetically from the cycles elapsed since reset. Running mode 1 with its two-clocks-per-pixel column separates a correct halving from a plain copy of the clock count, and it separates the per-mode bounds from a shared set. The mode input is toggled in the middle of a frame in both directions, which shows whether the captured mode is held. A reset is also applied in the middle of a frame, which shows that both counters restart together from zero.

// File: rtl/vga_tg_pkg.sv
package vga_tg_pkg;

    typedef enum logic {
        MODE_SVGA72 = 1'b0,
        MODE_VGA60  = 1'b1
    } vmode_e;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/vga_tg_bounds.sv
module vga_tg_bounds
    import vga_tg_pkg::*;
#(
    parameter int A_H_VIS  = 800,
    parameter int A_H_FP   = 16,
    parameter int A_H_SYNC = 120,
    parameter int A_H_BP   = 104,
    parameter int A_V_VIS  = 600,
    parameter int A_V_FP   = 37,
    parameter int A_V_SYNC = 6,
    parameter int A_V_BP   = 23,
    parameter int B_H_VIS  = 1280,
    parameter int B_H_FP   = 32,
    parameter int B_H_SYNC = 192,
    parameter int B_H_BP   = 96,
    parameter int B_V_VIS  = 480,
    parameter int B_V_FP   = 10,
    parameter int B_V_SYNC = 2,
    parameter int B_V_BP   = 29,
    parameter int B_SHIFT  = 1,
    parameter int HCW      = 11,
    parameter int VCW      = 10
) (
    input  vmode_e           mode_i,
    output logic [HCW-1:0]   h_last_o,
    output logic [HCW-1:0]   h_vis_o,
    output logic [HCW-1:0]   h_lo_o,
    output logic [HCW-1:0]   h_hi_o,
    output logic [VCW-1:0]   v_last_o,
    output logic [VCW-1:0]   v_vis_o,
    output logic [VCW-1:0]   v_lo_o,
    output logic [VCW-1:0]   v_hi_o,
    output logic [3:0]       shift_o
);

    localparam int A_H_LAST = A_H_VIS + A_H_FP + A_H_SYNC + A_H_BP - 1;
    localparam int B_H_LAST = B_H_VIS + B_H_FP + B_H_SYNC + B_H_BP - 1;
    localparam int A_V_LAST = A_V_VIS + A_V_FP + A_V_SYNC + A_V_BP - 1;
    localparam int B_V_LAST = B_V_VIS + B_V_FP + B_V_SYNC + B_V_BP - 1;

    typedef struct packed {
        logic [HCW-1:0] h_last;
        logic [HCW-1:0] h_vis;
        logic [HCW-1:0] h_lo;
        logic [HCW-1:0] h_hi;
        logic [VCW-1:0] v_last;
        logic [VCW-1:0] v_vis;
        logic [VCW-1:0] v_lo;
        logic [VCW-1:0] v_hi;
        logic [3:0]     shift;
    } bset_t;

    bset_t set_a;
    bset_t set_b;
    bset_t sel_d;

    always_comb begin
        set_a.h_last = HCW'(A_H_LAST);
        set_a.h_vis  = HCW'(A_H_VIS);
        set_a.h_lo   = HCW'(A_H_VIS + A_H_FP);
        set_a.h_hi   = HCW'(A_H_VIS + A_H_FP + A_H_SYNC - 1);
        set_a.v_last = VCW'(A_V_LAST);
        set_a.v_vis  = VCW'(A_V_VIS);
        set_a.v_lo   = VCW'(A_V_VIS + A_V_FP);
        set_a.v_hi   = VCW'(A_V_VIS + A_V_FP + A_V_SYNC - 1);
        set_a.shift  = 4'd0;

        set_b.h_last = HCW'(B_H_LAST);
        set_b.h_vis  = HCW'(B_H_VIS);
        set_b.h_lo   = HCW'(B_H_VIS + B_H_FP);
        set_b.h_hi   = HCW'(B_H_VIS + B_H_FP + B_H_SYNC - 1);
        set_b.v_last = VCW'(B_V_LAST);
        set_b.v_vis  = VCW'(B_V_VIS);
        set_b.v_lo   = VCW'(B_V_VIS + B_V_FP);
        set_b.v_hi   = VCW'(B_V_VIS + B_V_FP + B_V_SYNC - 1);
        set_b.shift  = 4'(B_SHIFT);

        sel_d = (mode_i == MODE_VGA60) ? set_b : set_a;
    end

    assign h_last_o = sel_d.h_last;
    assign h_vis_o  = sel_d.h_vis;
    assign h_lo_o   = sel_d.h_lo;
    assign h_hi_o   = sel_d.h_hi;
    assign v_last_o = sel_d.v_last;
    assign v_vis_o  = sel_d.v_vis;
    assign v_lo_o   = sel_d.v_lo;
    assign v_hi_o   = sel_d.v_hi;
    assign shift_o  = sel_d.shift;

endmodule

// File: rtl/vga_tg_axis.sv
module vga_tg_axis #(
    parameter int CW = 11
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          adv_i,
    input  logic [CW-1:0] last_i,
    input  logic [CW-1:0] vis_i,
    input  logic [CW-1:0] lo_i,
    input  logic [CW-1:0] hi_i,
    output logic [CW-1:0] cnt_o,
    output logic          wrap_o,
    output logic          in_vis_o,
    output logic          sync_n_o
);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } ax_t;

    ax_t ax_d;
    ax_t ax_q;
    logic at_last;

    always_comb begin
        at_last = (ax_q.cnt == last_i);
        ax_d    = ax_q;
        if (rst_i) begin
            ax_d.cnt = '0;
        end else if (adv_i) begin
            ax_d.cnt = at_last ? '0 : ax_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        ax_q <= ax_d;
    end

    assign cnt_o    = ax_q.cnt;
    assign wrap_o   = adv_i && at_last && !rst_i;
    assign in_vis_o = (ax_q.cnt < vis_i);
    assign sync_n_o = !((ax_q.cnt >= lo_i) && (ax_q.cnt <= hi_i));

    // R1 (and R2 through the row instance): the count wraps from its last value to zero
    assert_cnt_wrap_R1: assert property (@(posedge clk_i) disable iff (rst_i)
        (adv_i && cnt_o == last_i) |=> (cnt_o == '0));

    // R1: the count steps by one when enabled below its last value
    assert_cnt_step_R1: assert property (@(posedge clk_i) disable iff (rst_i)
        (adv_i && cnt_o != last_i) |=> (cnt_o == $past(cnt_o) + 1'b1));

    // R2: the count holds when not enabled
    assert_cnt_hold_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        (!adv_i) |=> $stable(cnt_o));

    // R8: reset leaves the count at zero
    assert_cnt_reset_R8: assert property (@(posedge clk_i)
        rst_i |=> (cnt_o == '0));

endmodule

// File: rtl/vga_sync_gen.sv
module vga_sync_gen
    import vga_tg_pkg::*;
#(
    parameter int A_H_VIS  = 800,
    parameter int A_H_FP   = 16,
    parameter int A_H_SYNC = 120,
    parameter int A_H_BP   = 104,
    parameter int A_V_VIS  = 600,
    parameter int A_V_FP   = 37,
    parameter int A_V_SYNC = 6,
    parameter int A_V_BP   = 23,
    parameter int B_H_VIS  = 1280,
    parameter int B_H_FP   = 32,
    parameter int B_H_SYNC = 192,
    parameter int B_H_BP   = 96,
    parameter int B_V_VIS  = 480,
    parameter int B_V_FP   = 10,
    parameter int B_V_SYNC = 2,
    parameter int B_V_BP   = 29,
    parameter int B_SHIFT  = 1,
    parameter int COL_W    = 11,
    parameter int ROW_W    = 10
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             mode_i,
    output logic             hsync_o,
    output logic             vsync_o,
    output logic             visible_o,
    output logic [COL_W-1:0] pix_col_o,
    output logic [ROW_W-1:0] pix_row_o,
    output logic             line_start_o
);

    localparam int A_H_TOT = A_H_VIS + A_H_FP + A_H_SYNC + A_H_BP;
    localparam int B_H_TOT = B_H_VIS + B_H_FP + B_H_SYNC + B_H_BP;
    localparam int A_V_TOT = A_V_VIS + A_V_FP + A_V_SYNC + A_V_BP;
    localparam int B_V_TOT = B_V_VIS + B_V_FP + B_V_SYNC + B_V_BP;
    localparam int HCW     = $clog2(imax(A_H_TOT, B_H_TOT));
    localparam int VCW     = $clog2(imax(A_V_TOT, B_V_TOT));

    typedef struct packed {
        vmode_e mode;
        logic   strobe;
    } top_t;

    top_t st_d;
    top_t st_q;

    logic [HCW-1:0] h_last, h_vis, h_lo, h_hi, h_cnt;
    logic [VCW-1:0] v_last, v_vis, v_lo, v_hi, v_cnt;
    logic [3:0]     shift;
    logic           h_wrap, v_wrap;
    logic           h_in, v_in, h_sn, v_sn;
    logic [HCW-1:0] col_scaled;

    vga_tg_bounds #(
        .A_H_VIS(A_H_VIS), .A_H_FP(A_H_FP), .A_H_SYNC(A_H_SYNC), .A_H_BP(A_H_BP),
        .A_V_VIS(A_V_VIS), .A_V_FP(A_V_FP), .A_V_SYNC(A_V_SYNC), .A_V_BP(A_V_BP),
        .B_H_VIS(B_H_VIS), .B_H_FP(B_H_FP), .B_H_SYNC(B_H_SYNC), .B_H_BP(B_H_BP),
        .B_V_VIS(B_V_VIS), .B_V_FP(B_V_FP), .B_V_SYNC(B_V_SYNC), .B_V_BP(B_V_BP),
        .B_SHIFT(B_SHIFT), .HCW(HCW), .VCW(VCW)
    ) i_bounds (
        .mode_i   (st_q.mode),
        .h_last_o (h_last),
        .h_vis_o  (h_vis),
        .h_lo_o   (h_lo),
        .h_hi_o   (h_hi),
        .v_last_o (v_last),
        .v_vis_o  (v_vis),
        .v_lo_o   (v_lo),
        .v_hi_o   (v_hi),
        .shift_o  (shift)
    );

    vga_tg_axis #(.CW(HCW)) i_hax (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .adv_i    (1'b1),
        .last_i   (h_last),
        .vis_i    (h_vis),
        .lo_i     (h_lo),
        .hi_i     (h_hi),
        .cnt_o    (h_cnt),
        .wrap_o   (h_wrap),
        .in_vis_o (h_in),
        .sync_n_o (h_sn)
    );

    // The row advances on the strobe's next value: the clock count reaching zero.
    vga_tg_axis #(.CW(VCW)) i_vax (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .adv_i    (st_d.strobe && !rst_i),
        .last_i   (v_last),
        .vis_i    (v_vis),
        .lo_i     (v_lo),
        .hi_i     (v_hi),
        .cnt_o    (v_cnt),
        .wrap_o   (v_wrap),
        .in_vis_o (v_in),
        .sync_n_o (v_sn)
    );

    always_comb begin
        st_d = st_q;
        if (rst_i) begin
            st_d.mode   = vmode_e'(mode_i);
            st_d.strobe = 1'b1;
        end else begin
            st_d.strobe = h_wrap;
        end
    end

    always_ff @(posedge clk_i) begin
        st_q <= st_d;
    end

    generate
        if (B_SHIFT == 0) begin : g_noscale
            assign col_scaled = h_cnt;
        end else begin : g_scale
            assign col_scaled = h_cnt >> shift;
        end
    endgenerate

    assign hsync_o      = h_sn;
    assign vsync_o      = v_sn;
    assign visible_o    = h_in && v_in;
    assign pix_col_o    = COL_W'(col_scaled);
    assign pix_row_o    = ROW_W'(v_cnt);
    assign line_start_o = st_q.strobe;

    // R6: the row moves only in a cycle flagged as a line start
    assert_row_on_strobe_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        (pix_row_o != $past(pix_row_o)) |-> line_start_o);

    // R6: the strobe never lasts two clocks
    assert_strobe_single_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        line_start_o |=> !line_start_o);

    // R3 and R4: no sync pulse inside the visible area
    assert_sync_in_blank_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        visible_o |-> (hsync_o && vsync_o));

    // R7: the reported column stays inside the visible width
    assert_col_range_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        visible_o |-> (int'(pix_col_o) <
            ((st_q.mode == MODE_VGA60) ? (B_H_VIS >> B_SHIFT) : A_H_VIS)));

    // R9: the captured mode holds outside reset
    assert_mode_hold_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        1'b1 |=> $stable(st_q.mode));

    // R8: reset drives both syncs high and raises the strobe
    assert_reset_state_R8: assert property (@(posedge clk_i)
        rst_i |=> (hsync_o && vsync_o && line_start_o));

endmodule

// File: tb/test_vga_sync_gen.sv
module test_vga_sync_gen;

    localparam int AHV = 8,  AHF = 2, AHS = 3, AHB = 2;
    localparam int AVV = 4,  AVF = 1, AVS = 2, AVB = 1;
    localparam int BHV = 12, BHF = 2, BHS = 4, BHB = 2;
    localparam int BVV = 3,  BVF = 1, BVS = 1, BVB = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mode = 1'b0;
    logic        hsync, vsync, visible, lstart;
    logic [10:0] pcol;
    logic [9:0]  prow;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    vga_sync_gen #(
        .A_H_VIS(AHV), .A_H_FP(AHF), .A_H_SYNC(AHS), .A_H_BP(AHB),
        .A_V_VIS(AVV), .A_V_FP(AVF), .A_V_SYNC(AVS), .A_V_BP(AVB),
        .B_H_VIS(BHV), .B_H_FP(BHF), .B_H_SYNC(BHS), .B_H_BP(BHB),
        .B_V_VIS(BVV), .B_V_FP(BVF), .B_V_SYNC(BVS), .B_V_BP(BVB),
        .B_SHIFT(1), .COL_W(11), .ROW_W(10)
    ) i_vga_sync_gen (
        .clk_i(clk), .rst_i(rst), .mode_i(mode),
        .hsync_o(hsync), .vsync_o(vsync), .visible_o(visible),
        .pix_col_o(pcol), .pix_row_o(prow), .line_start_o(lstart)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Follow k cycles after reset release in mode m; flip mode_i at cycle flip_at.
    task automatic sweep(input int m, input int cycles, input int flip_at);
        int ht, vt, hv, hl, hh, vv, vl, vh, sh;
        bit flipped;
        ht = m ? (BHV+BHF+BHS+BHB) : (AHV+AHF+AHS+AHB);
        vt = m ? (BVV+BVF+BVS+BVB) : (AVV+AVF+AVS+AVB);
        hv = m ? BHV : AHV;
        hl = m ? (BHV+BHF) : (AHV+AHF);
        hh = m ? (BHV+BHF+BHS-1) : (AHV+AHF+AHS-1);
        vv = m ? BVV : AVV;
        vl = m ? (BVV+BVF) : (AVV+AVF);
        vh = m ? (BVV+BVF+BVS-1) : (AVV+AVF+AVS-1);
        sh = m ? 1 : 0;
        flipped = 1'b0;
        mode = m[0];
        rst  = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        for (int k = 0; k <= cycles; k++) begin
            int hc, row;
            if (k > 0) begin
                @(posedge clk);
                @(negedge clk);
            end
            if (k == flip_at) begin
                mode = ~mode;
                flipped = 1'b1;
            end
            hc  = k % ht;
            row = (k / ht) % vt;
            chk((k == 0) ? "R8" : (flipped ? "R9" : (m ? "R7" : "R1")),
                "column", int'(pcol), hc >> sh);
            chk((k == 0) ? "R8" : (flipped ? "R9" : "R2"), "row", int'(prow), row);
            chk((k == 0) ? "R8" : (flipped ? "R9" : "R3"), "hsync",
                int'(hsync), (hc >= hl && hc <= hh) ? 0 : 1);
            chk((k == 0) ? "R8" : (flipped ? "R9" : "R4"), "vsync",
                int'(vsync), (row >= vl && row <= vh) ? 0 : 1);
            chk(flipped ? "R9" : "R5", "visible", int'(visible),
                (hc < hv && row < vv) ? 1 : 0);
            chk((k == 0) ? "R8" : (flipped ? "R9" : "R6"), "line_start",
                int'(lstart), (hc == 0) ? 1 : 0);
        end
    endtask

    initial begin
        // mode 0: two frames plus a few cycles, mode flipped mid-frame (R9)
        sweep(0, 2 * 15 * 8 + 5, 53);
        // mode 1 entered by a reset in the middle of a frame (R7, R8)
        sweep(1, 2 * 20 * 7 + 5, 97);
        // back to mode 0 with no flip (R1..R6)
        sweep(0, 15 * 8 + 20, -1);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int w = 0; w < 20000; w++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule